// File: doc/BRIEF.md
# Deferred floating-point exception unit

This unit sits between a floating-point execution stage and register writeback and decides what happens when an operation misbehaves. A mode input picks one of two policies. Under the precise policy, an arithmetic result that raised any exception flag is dropped and a trap request goes out in the same cycle. Under the deferred policy, arithmetic never traps. The fault is instead encoded in the written value: a signed infinity for overflow and a quiet NaN for invalid operation or divide by zero. Underflow is let through unmarked.

Under the deferred policy, the markers are checked only when a value leaves the floating-point domain. A user store checks its data, a float-to-integer conversion checks its source, and a compare checks both operands. A register spill store is never checked, so a marked value can be saved and restored without a trap. This lets a scheduler hoist chains of floating-point work above a branch: any fault on a path that is not taken stays silent. Values are IEEE-754 single precision by default.

Top module: `fpx_defer_unit`

## Requirements
- R1: With `mode_defer`=0, an arithmetic operation (`op_cls`=0) carrying any flag bit raises `trap_req` combinationally in its input cycle, with `trap_cause`=0 (arithmetic), and nothing is written back. Flag bits are: bit0 overflow, bit1 underflow, bit2 invalid, bit3 divide-by-zero.
- R2: With `mode_defer`=1, an arithmetic operation never raises `trap_req`, whatever its flags.
- R3: Deferred overflow without the invalid or divide-by-zero flag writes back, one cycle later, an infinity that keeps the sign bit of `res_in`: 0x7F800000 or 0xFF800000.
- R4: Deferred invalid or divide-by-zero writes back the quiet NaN 0x7FC00000. This holds even when overflow is flagged at the same time.
- R5: Deferred underflow alone writes `res_in` back unchanged, and no later consumer can tell that it happened.
- R6: In deferred mode, a user store (`op_cls`=1) whose `opnd_a` is NaN or infinity (exponent all ones) traps with `trap_cause`=1. Stores never write back.
- R7: A spill/restore store (`op_cls`=2) never traps, whatever its operand.
- R8: In deferred mode, a conversion to integer (`op_cls`=3) whose `opnd_a` is NaN or infinity traps with `trap_cause`=2 and writes nothing back.
- R9: In deferred mode, a compare (`op_cls`=4) whose `opnd_a` or `opnd_b` is NaN or infinity traps with `trap_cause`=3 and writes nothing back.
- R10: The following write `res_in` (or the deferred substitute) to `wb_data` with `wb_valid` high on the next cycle: a non-trapping arithmetic, conversion or compare. Flags are ignored outside arithmetic. In precise mode, consumers never check their operands. Classes 5 to 7 and idle cycles produce neither writeback nor trap.
- R11: While `rst_n` is low, `wb_valid` and `trap_req` are low. Inputs stay ignored until the second rising clock edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | An operation is presented this cycle |
| mode_defer | input | 1 | 1 selects the deferred policy, 0 the precise policy |
| op_cls | input | 3 | Operation class: 0 arith, 1 user store, 2 spill store, 3 convert, 4 compare |
| exc_flags | input | 4 | Exception flags of the arithmetic result |
| res_in | input | 32 | Result word from the execution stage |
| opnd_a | input | 32 | First consumed operand (store data, convert source, compare left) |
| opnd_b | input | 32 | Second compare operand |
| wb_valid | output | 1 | Registered writeback strobe |
| wb_data | output | 32 | Registered writeback value |
| trap_req | output | 1 | Trap request, one cycle per faulting operation |
| trap_cause | output | 2 | 0 arithmetic, 1 store, 2 convert, 3 compare |

## Verification
The hardest situation to reach is a fault that is deferred once and then caught later. A flagged arithmetic result has to come back as a consumer operand, and it must trap only at the right consumer class and mode. The bench feeds the exact infinity and NaN words that the deferred policy writes back into stores, conversions and compares. It does this in both modes and through the spill store. A randomized phase then mixes flag patterns, reserved classes and special operands against an independent model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [2:0] {
    CLS_ARITH    = 3'd0,
    CLS_ST_USER  = 3'd1,
    CLS_ST_SPILL = 3'd2,
    CLS_CVT      = 3'd3,
    CLS_CMP      = 3'd4
  } fpx_cls_e;

  typedef enum logic [1:0] {
    CAUSE_ARITH = 2'd0,
    CAUSE_STORE = 2'd1,
    CAUSE_CVT   = 2'd2,
    CAUSE_CMP   = 2'd3
  } fpx_cause_e;

  localparam int FLG_OVF = 0;
  localparam int FLG_UNF = 1;
  localparam int FLG_INV = 2;
  localparam int FLG_DZ  = 3;
  localparam int FLG_W   = 4;
endpackage

// File: rtl/fpx_rst_sync.sv
module fpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpx_special_det.sv
module fpx_special_det #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output logic         is_inf,
  output logic         is_nan
);
  logic exp_max;
  logic frac_zero;

  always_comb begin
    exp_max   = &val[W-2:FRAC_W];
    frac_zero = (val[FRAC_W-1:0] == '0);
    is_inf    = exp_max && frac_zero;
    is_nan    = exp_max && !frac_zero;
  end
endmodule

// File: rtl/fpx_subst.sv
module fpx_subst
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic             defer,
  input  logic [FLG_W-1:0] flags,
  input  logic [W-1:0]     res,
  output logic [W-1:0]     data,
  output logic             exc_any
);
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [FRAC_W-1:0] QNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};

  logic nan_case;
  logic inf_case;

  always_comb begin
    exc_any  = |flags;
    nan_case = flags[FLG_INV] || flags[FLG_DZ];
    inf_case = flags[FLG_OVF] && !nan_case;
    data     = res;
    if (defer) begin
      // the invalid or divide-by-zero marker wins over the overflow marker
      if (nan_case)      data = {1'b0, EXP_ONES, QNAN_FRAC};
      else if (inf_case) data = {res[W-1], EXP_ONES, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fpx_policy.sv
module fpx_policy
  import fpx_pkg::*;
(
  input  logic       vld,
  input  logic       defer,
  input  logic [2:0] cls,
  input  logic       exc_any,
  input  logic       spec_a,
  input  logic       spec_b,
  output logic       trap,
  output logic [1:0] cause,
  output logic       wb_en,
  output logic       sel_sub
);
  fpx_cls_e c;

  always_comb begin
    c       = fpx_cls_e'(cls);
    trap    = 1'b0;
    cause   = CAUSE_ARITH;
    wb_en   = 1'b0;
    sel_sub = 1'b0;
    if (vld) begin
      unique case (c)
        CLS_ARITH: begin
          sel_sub = 1'b1;
          if (!defer && exc_any) trap = 1'b1;
          else                   wb_en = 1'b1;
        end
        CLS_ST_USER: begin
          if (defer && spec_a) begin
            trap  = 1'b1;
            cause = CAUSE_STORE;
          end
        end
        CLS_ST_SPILL: begin
          trap = 1'b0;
        end
        CLS_CVT: begin
          if (defer && spec_a) begin
            trap  = 1'b1;
            cause = CAUSE_CVT;
          end else begin
            wb_en = 1'b1;
          end
        end
        CLS_CMP: begin
          if (defer && (spec_a || spec_b)) begin
            trap  = 1'b1;
            cause = CAUSE_CMP;
          end else begin
            wb_en = 1'b1;
          end
        end
        default: begin
          trap = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpx_defer_unit.sv
module fpx_defer_unit
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int SYNC_STAGES = 2,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             mode_defer,
  input  logic [2:0]       op_cls,
  input  logic [FLG_W-1:0] exc_flags,
  input  logic [W-1:0]     res_in,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  output logic             wb_valid,
  output logic [W-1:0]     wb_data,
  output logic             trap_req,
  output logic [1:0]       trap_cause
);
  localparam int NOPND = 2;

  logic             rst_s_n;
  logic             vld;
  logic [W-1:0]     opnd [NOPND];
  logic [NOPND-1:0] op_inf;
  logic [NOPND-1:0] op_nan;
  logic [NOPND-1:0] op_spec;
  logic [W-1:0]     sub_data;
  logic             exc_any;
  logic             wb_en;
  logic             sel_sub;

  logic             wb_valid_q, wb_valid_d;
  logic [W-1:0]     wb_data_q, wb_data_d;

  fpx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign vld     = in_valid && rst_s_n;
  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar i = 0; i < NOPND; i++) begin : g_det
    fpx_special_det #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_det (
      .val    (opnd[i]),
      .is_inf (op_inf[i]),
      .is_nan (op_nan[i])
    );
    assign op_spec[i] = op_inf[i] || op_nan[i];
  end

  fpx_subst #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_subst (
    .defer   (mode_defer),
    .flags   (exc_flags),
    .res     (res_in),
    .data    (sub_data),
    .exc_any (exc_any)
  );

  fpx_policy u_pol (
    .vld     (vld),
    .defer   (mode_defer),
    .cls     (op_cls),
    .exc_any (exc_any),
    .spec_a  (op_spec[0]),
    .spec_b  (op_spec[1]),
    .trap    (trap_req),
    .cause   (trap_cause),
    .wb_en   (wb_en),
    .sel_sub (sel_sub)
  );

  // next-state for the writeback stage; data register loads only when enabled
  always_comb begin
    wb_valid_d = wb_en;
    wb_data_d  = wb_data_q;
    if (wb_en) wb_data_d = sel_sub ? sub_data : res_in;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wb_valid_q <= 1'b0;
      wb_data_q  <= '0;
    end else begin
      wb_valid_q <= wb_valid_d;
      wb_data_q  <= wb_data_d;
    end
  end

  assign wb_valid = wb_valid_q;
  assign wb_data  = wb_data_q;
endmodule

// File: rtl/fpx_defer_chk.sv
module fpx_defer_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         mode_defer,
  input logic [2:0]   op_cls,
  input logic [3:0]   exc_flags,
  input logic [W-1:0] res_in,
  input logic         wb_valid,
  input logic [W-1:0] wb_data,
  input logic         trap_req,
  input logic [1:0]   trap_cause
);
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // R2
  no_defer_arith_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_defer && op_cls == 3'd0) |-> !trap_req);

  // R7
  no_spill_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_cls == 3'd2) |-> !trap_req);

  // R1
  precise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !mode_defer) |-> (trap_cause == 2'd0));

  // R8
  trap_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !wb_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !trap_req);

  // R3
  defer_ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_defer && op_cls == 3'd0 && exc_flags[0] && !exc_flags[2] && !exc_flags[3])
    |=> (wb_valid && wb_data == {$past(res_in[W-1]), INF_MAG}));

  // R4
  defer_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_defer && op_cls == 3'd0 && (exc_flags[2] || exc_flags[3]))
    |=> (wb_valid && wb_data == QNAN));
endmodule

bind fpx_defer_unit fpx_defer_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .in_valid   (in_valid),
  .mode_defer (mode_defer),
  .op_cls     (op_cls),
  .exc_flags  (exc_flags),
  .res_in     (res_in),
  .wb_valid   (wb_valid),
  .wb_data    (wb_data),
  .trap_req   (trap_req),
  .trap_cause (trap_cause)
);

// File: tb/fpx_defer_unit_test.sv
`timescale 1ns/1ps
module fpx_defer_unit_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        mode_defer;
  logic [2:0]  op_cls;
  logic [3:0]  exc_flags;
  logic [31:0] res_in, opnd_a, opnd_b;
  logic        wb_valid;
  logic [31:0] wb_data;
  logic        trap_req;
  logic [1:0]  trap_cause;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic        v;
    logic [31:0] d;
    string       tag;
  } wb_item_t;

  wb_item_t q[$];

  localparam logic [31:0] PINF = 32'h7F800000;
  localparam logic [31:0] NINF = 32'hFF800000;
  localparam logic [31:0] QNAN = 32'h7FC00000;
  localparam logic [31:0] SNAN = 32'h7F800001;
  localparam logic [31:0] ONE  = 32'h3F800000;
  localparam logic [31:0] NEG2 = 32'hC0000000;

  fpx_defer_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_defer(mode_defer),
    .op_cls(op_cls), .exc_flags(exc_flags), .res_in(res_in),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .wb_valid(wb_valid), .wb_data(wb_data),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit spec(input logic [31:0] x);
    return x[30:23] == 8'hFF;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: computes the expected outcome from the requirements
  task automatic drive(input string tag, input bit v, input bit m, input logic [2:0] c,
                       input logic [3:0] f, input logic [31:0] r,
                       input logic [31:0] a, input logic [31:0] b);
    bit          etrap = 0;
    logic [1:0]  ecause = 2'd0;
    bit          ewb = 0;
    logic [31:0] ed = r;
    wb_item_t    it;
    if (v) begin
      case (c)
        3'd0: begin
          if (!m && f != 4'd0) etrap = 1;
          else begin
            ewb = 1;
            if (m && (f[2] || f[3])) ed = QNAN;
            else if (m && f[0]) ed = {r[31], 31'h7F800000};
          end
        end
        3'd1: if (m && spec(a)) begin etrap = 1; ecause = 2'd1; end
        3'd2: ;
        3'd3: if (m && spec(a)) begin etrap = 1; ecause = 2'd2; end else ewb = 1;
        3'd4: if (m && (spec(a) || spec(b))) begin etrap = 1; ecause = 2'd3; end else ewb = 1;
        default: ;
      endcase
    end
    @(negedge clk);
    in_valid = v; mode_defer = m; op_cls = c; exc_flags = f;
    res_in = r; opnd_a = a; opnd_b = b;
    #1;
    check(trap_req == etrap && (!etrap || trap_cause == ecause), tag, "trap/cause",
          {trap_req, trap_cause}, {etrap, ecause});
    it.v = ewb; it.d = ed; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares the registered writeback against the queue
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      wb_item_t it;
      it = q.pop_front();
      check(wb_valid == it.v && (!it.v || wb_data == it.d), it.tag, "writeback",
            {wb_valid, wb_data}, {it.v, it.d});
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 1; mode_defer = 0; op_cls = 3'd0; exc_flags = 4'b0001;
    res_in = ONE; opnd_a = PINF; opnd_b = 0;
    repeat (3) @(negedge clk);
    #1;
    // R11: reset holds outputs low even with a faulting input present
    check(!wb_valid && !trap_req, "R11", "in reset", {wb_valid, trap_req}, 2'b00);
    rst_n = 1;
    #1;
    check(!trap_req, "R11", "just released", trap_req, 0);
    @(negedge clk); #1;
    check(!trap_req && !wb_valid, "R11", "one edge after release", {wb_valid, trap_req}, 2'b00);
    in_valid = 0;
    @(negedge clk);
    @(negedge clk);

    // precise policy
    drive("R1", 1, 0, 3'd0, 4'b0001, ONE, 0, 0);
    drive("R1", 1, 0, 3'd0, 4'b0010, ONE, 0, 0);
    drive("R1", 1, 0, 3'd0, 4'b0100, ONE, 0, 0);
    drive("R10", 1, 0, 3'd0, 4'b0000, NEG2, 0, 0);
    drive("R10", 1, 0, 3'd1, 4'b0000, 0, QNAN, 0);
    drive("R10", 1, 0, 3'd3, 4'b0000, 32'd7, PINF, 0);
    drive("R10", 1, 0, 3'd4, 4'b0000, 32'd1, NINF, SNAN);
    // deferred substitutions
    drive("R2", 1, 1, 3'd0, 4'b1111, ONE, 0, 0);
    drive("R3", 1, 1, 3'd0, 4'b0001, 32'h7F7FFFFF, 0, 0);
    drive("R3", 1, 1, 3'd0, 4'b0001, 32'hFF7FFFFF, 0, 0);
    drive("R4", 1, 1, 3'd0, 4'b0100, ONE, 0, 0);
    drive("R4", 1, 1, 3'd0, 4'b1000, NEG2, 0, 0);
    drive("R4", 1, 1, 3'd0, 4'b0101, NEG2, 0, 0);
    drive("R5", 1, 1, 3'd0, 4'b0010, 32'h00000003, 0, 0);
    // deferred consumers fed with the markers written above
    drive("R6", 1, 1, 3'd1, 4'b0000, 0, PINF, 0);
    drive("R6", 1, 1, 3'd1, 4'b0000, 0, QNAN, 0);
    drive("R6", 1, 1, 3'd1, 4'b0000, 0, ONE, QNAN);
    drive("R7", 1, 1, 3'd2, 4'b0000, 0, QNAN, 0);
    drive("R7", 1, 1, 3'd2, 4'b0000, 0, NINF, 0);
    drive("R8", 1, 1, 3'd3, 4'b0000, 32'd5, NINF, 0);
    drive("R8", 1, 1, 3'd3, 4'b0000, 32'd5, SNAN, 0);
    drive("R8", 1, 1, 3'd3, 4'b0000, 32'd9, ONE, 0);
    drive("R9", 1, 1, 3'd4, 4'b0000, 32'd1, ONE, PINF);
    drive("R9", 1, 1, 3'd4, 4'b0000, 32'd1, QNAN, ONE);
    drive("R9", 1, 1, 3'd4, 4'b0000, 32'd1, ONE, NEG2);
    // flags ignored outside arithmetic, reserved classes and idle cycles inert
    drive("R10", 1, 0, 3'd3, 4'b1111, 32'd11, ONE, 0);
    drive("R10", 1, 1, 3'd5, 4'b1111, ONE, QNAN, QNAN);
    drive("R10", 1, 1, 3'd7, 4'b0001, ONE, PINF, PINF);
    drive("R10", 0, 1, 3'd1, 4'b0000, ONE, PINF, 0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] pick [4];
      pick[0] = $urandom; pick[1] = PINF | ({31'd0, 1'b1} << 31) * ($urandom % 2);
      pick[2] = {1'b0, 8'hFF, 23'($urandom) | 23'd1}; pick[3] = {1'b0, 8'h40, 23'($urandom)};
      drive("R10", ($urandom % 8) != 0, $urandom % 2, 3'($urandom), 4'($urandom),
            pick[$urandom % 4], pick[$urandom % 4], pick[$urandom % 4]);
    end

    drive("R10", 0, 0, 3'd0, 4'b0000, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule